// File: doc/BRIEF.md
# Edge-Cleared Watchdog Timer

This block watches a single watchdog input for signs of life. Every change of level on that input, rising or falling, restarts a timeout count. If the input sits at one level, high or low, for the full timeout period, the active-low fault output goes low. It stays low until the input moves again. System software normally toggles the input from a periodic task. The fault output can be routed to whatever handles a stalled processor.

The input is really three-level. A floating input cannot be sensed digitally, so that case arrives as a separate flag, and while the flag is set the watchdog is disabled. A system-reset-active input holds the count at zero. A supply-low flag forces the fault output low for as long as it is set, and the output returns high as soon as the flag drops. The watchdog input passes through a two-flop synchronizer. Edges are found by comparing the newest synchronized sample with the one before it. The timeout is a parameter in clock ticks. Its default is 1.6 s at a 125 MHz clock.

Top module: `edge_wdt`

## Requirements
- R1: A rising or a falling edge on `wd_in_i` clears the timeout count, and the clear is applied on the third rising clock edge after the input changes (two synchronizer stages plus the edge register). When that clear falls on the same cycle in which the count would reach `TIMEOUT_TICKS`, the clear wins and no fault is raised.
- R2: If no clear condition occurs, the count advances by one per clock. `wd_fault_no` goes low when the count reaches `TIMEOUT_TICKS`, which is the `TIMEOUT_TICKS`-th clock after the clearing clock. This holds whether the input is held high or held low.
- R3: Once low because of a timeout, `wd_fault_no` stays low until a clear condition occurs. The count saturates and does not wrap.
- R4: While `sys_rst_i` is 1, the count is held at zero and the watchdog raises no fault.
- R5: While `wd_float_i` is 1, the count is held at zero and `wd_fault_no` is not driven low by a timeout. After the flag clears, counting resumes from zero.
- R6: While `supply_low_i` is 1, `wd_fault_no` is 0 in the same cycle, with no register in the path, and the count is held at zero.
- R7: When `supply_low_i` returns to 0, `wd_fault_no` returns to 1 in the same cycle.
- R8: While `rst_ni` is 0, the count is zero and `wd_fault_no` is 1, independent of the clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wd_in_i | input | 1 | Watchdog input to monitor; asynchronous |
| wd_float_i | input | 1 | Input-floating flag; 1 disables the watchdog |
| sys_rst_i | input | 1 | System reset active; 1 holds the count at zero |
| supply_low_i | input | 1 | Supply-low flag; 1 forces the fault output low |
| wd_fault_no | output | 1 | Watchdog fault, active low |

## Verification
Two events can land on the same clock: an edge-driven clear, and the count reaching its limit. The bench holds the input for exactly three cycles fewer than the timeout and then toggles it. The synchronizer delay therefore lands the clear on the very clock where the count would otherwise hit the limit. The output is judged to stay high, and it must then fall a full period later. A second pairing is a supply-low pulse over a running count. It is judged by an output that is low in the same cycle and high in the same cycle the flag drops, with the count restarted from zero.

// File: rtl/edge_wdt_pkg.sv
package edge_wdt_pkg;
  // 1.6 s at 125 MHz
  localparam int unsigned DEF_TIMEOUT_TICKS = 200_000_000;
  localparam int unsigned DEF_SYNC_STAGES   = 2;

  typedef struct packed {
    logic in_edge;
    logic sys_rst;
    logic floating;
    logic supply_low;
  } clr_src_t;

  function automatic logic any_clear(clr_src_t s);
    return s.in_edge | s.sys_rst | s.floating | s.supply_low;
  endfunction
endpackage

// File: rtl/edge_wdt_sync.sv
module edge_wdt_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic level_o,
  output logic edge_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sync_q[0] <= 1'b0;
          else         sync_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sync_q[g] <= 1'b0;
          else         sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[STAGES-1];
  end

  assign level_o = sync_q[STAGES-1];
  assign edge_o  = sync_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/edge_wdt_counter.sv
module edge_wdt_counter #(
  parameter int unsigned TIMEOUT_TICKS = 20,
  localparam int unsigned CW = $clog2(TIMEOUT_TICKS + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  output logic [CW-1:0] cnt_o,
  output logic          expired_o
);
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT_TICKS);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (clear_i)        cnt_q <= '0;
    else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o     = cnt_q;
  assign expired_o = (cnt_q == LIMIT);
endmodule

// File: rtl/edge_wdt_fault.sv
module edge_wdt_fault (
  input  logic expired_i,
  input  logic supply_low_i,
  output logic fault_no
);
  // supply-low bypasses all registers
  assign fault_no = ~(expired_i | supply_low_i);
endmodule

// File: rtl/edge_wdt.sv
module edge_wdt
  import edge_wdt_pkg::*;
#(
  parameter int unsigned TIMEOUT_TICKS = DEF_TIMEOUT_TICKS,
  parameter int unsigned SYNC_STAGES   = DEF_SYNC_STAGES,
  localparam int unsigned CW = $clog2(TIMEOUT_TICKS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wd_in_i,
  input  logic wd_float_i,
  input  logic sys_rst_i,
  input  logic supply_low_i,
  output logic wd_fault_no
);
  logic          in_level;
  logic          in_edge;
  logic          expired;
  logic [CW-1:0] cnt_q;
  clr_src_t      clr_src;
  logic          clear;

  edge_wdt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (wd_in_i),
    .level_o(in_level),
    .edge_o (in_edge)
  );

  assign clr_src = '{in_edge: in_edge, sys_rst: sys_rst_i,
                     floating: wd_float_i, supply_low: supply_low_i};
  assign clear   = any_clear(clr_src);

  edge_wdt_counter #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (clear),
    .cnt_o    (cnt_q),
    .expired_o(expired)
  );

  edge_wdt_fault u_fault (
    .expired_i   (expired),
    .supply_low_i(supply_low_i),
    .fault_no    (wd_fault_no)
  );

  logic unused_level;
  assign unused_level = in_level;
endmodule

// File: rtl/edge_wdt_chk.sv
module edge_wdt_chk #(
  parameter int unsigned TIMEOUT_TICKS = 20,
  localparam int unsigned CW = $clog2(TIMEOUT_TICKS + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wd_float_i,
  input logic          sys_rst_i,
  input logic          supply_low_i,
  input logic          wd_fault_no,
  input logic          in_edge,
  input logic [CW-1:0] cnt_q
);
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT_TICKS);
  logic quiet;
  assign quiet = !in_edge && !sys_rst_i && !wd_float_i && !supply_low_i;

  p_edge_clear_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_edge |=> cnt_q == '0);
  p_count_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (quiet && cnt_q != LIMIT) |=> cnt_q == $past(cnt_q) + 1'b1);
  p_fault_at_limit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q == LIMIT |-> !wd_fault_no);
  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LIMIT);
  p_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (quiet && cnt_q == LIMIT) |=> !wd_fault_no);
  p_sys_rst_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_i |=> cnt_q == '0);
  p_float_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_float_i |=> cnt_q == '0);
  p_supply_force_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    supply_low_i |-> !wd_fault_no);
  p_supply_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!supply_low_i && $past(supply_low_i) && cnt_q != LIMIT) |-> wd_fault_no);
endmodule

bind edge_wdt edge_wdt_chk #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wd_float_i  (wd_float_i),
  .sys_rst_i   (sys_rst_i),
  .supply_low_i(supply_low_i),
  .wd_fault_no (wd_fault_no),
  .in_edge     (in_edge),
  .cnt_q       (cnt_q)
);

// File: tb/edge_wdt_tb_top.sv
module edge_wdt_tb_top;
  localparam int unsigned T = 20;

  typedef struct packed {
    logic        wd_in;
    logic        flt;
    logic        srst;
    logic        slow;
    logic [15:0] hold;
    logic        exp_n;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 1'b0, 1'b0, 16'(T+2), 1'b1, 8'd2}, // R2 one short of limit
    '{1'b1, 1'b0, 1'b0, 1'b0, 16'd1,    1'b0, 8'd2}, // R2 high held
    '{1'b1, 1'b0, 1'b0, 1'b0, 16'd5,    1'b0, 8'd3}, // R3 sticky
    '{1'b0, 1'b0, 1'b0, 1'b0, 16'd2,    1'b0, 8'd3}, // R3 before clear lands
    '{1'b0, 1'b0, 1'b0, 1'b0, 16'd1,    1'b1, 8'd1}, // R1 falling edge clears
    '{1'b0, 1'b0, 1'b0, 1'b0, 16'(T-1), 1'b1, 8'd2}, // R2
    '{1'b0, 1'b0, 1'b0, 1'b0, 16'd1,    1'b0, 8'd2}, // R2 low held
    '{1'b0, 1'b1, 1'b0, 1'b0, 16'd1,    1'b1, 8'd5}, // R5 float clears
    '{1'b0, 1'b1, 1'b0, 1'b0, 16'(3*T), 1'b1, 8'd5}, // R5 disabled
    '{1'b0, 1'b0, 1'b0, 1'b0, 16'(T-1), 1'b1, 8'd5}, // R5 restart from zero
    '{1'b0, 1'b0, 1'b0, 1'b0, 16'd1,    1'b0, 8'd2}, // R2
    '{1'b0, 1'b0, 1'b1, 1'b0, 16'd1,    1'b1, 8'd4}, // R4 clears
    '{1'b0, 1'b0, 1'b1, 1'b0, 16'(2*T), 1'b1, 8'd4}, // R4 held
    '{1'b0, 1'b0, 1'b0, 1'b1, 16'(T+5), 1'b0, 8'd6}, // R6 forced low
    '{1'b0, 1'b0, 1'b0, 1'b0, 16'd1,    1'b1, 8'd7}, // R7 released
    '{1'b1, 1'b0, 1'b0, 1'b0, 16'(T+2), 1'b1, 8'd1}, // R1 rising edge restarts
    '{1'b1, 1'b0, 1'b0, 1'b0, 16'd1,    1'b0, 8'd2}, // R2
    '{1'b0, 1'b0, 1'b0, 1'b0, 16'd3,    1'b1, 8'd1}, // R1 edge ends fault
    '{1'b0, 1'b0, 1'b0, 1'b0, 16'(T-3), 1'b1, 8'd2}, // R2
    '{1'b1, 1'b0, 1'b0, 1'b0, 16'd3,    1'b1, 8'd1}, // R1 clear beats limit
    '{1'b1, 1'b0, 1'b0, 1'b0, 16'(T),   1'b0, 8'd2}  // R2 full period after
  };

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic wd_in_i = 1'b0;
  logic wd_float_i = 1'b0;
  logic sys_rst_i = 1'b0;
  logic supply_low_i = 1'b0;
  logic wd_fault_no;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  edge_wdt #(.TIMEOUT_TICKS(T)) dut_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wd_in_i     (wd_in_i),
    .wd_float_i  (wd_float_i),
    .sys_rst_i   (sys_rst_i),
    .supply_low_i(supply_low_i),
    .wd_fault_no (wd_fault_no)
  );

  task automatic check(input logic exp_n, input int req, input int idx);
    n_checks++;
    if (wd_fault_no !== exp_n) begin
      n_fail++;
      $display("FAIL R%0d step %0d: wd_fault_no=%b expected %b", req, idx, wd_fault_no, exp_n);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    #1 check(1'b1, 8, -1); // R8 during reset
    @(negedge clk_i);
    rst_ni = 1'b1;
    for (int i = 0; i < NV; i++) begin
      wd_in_i      = VECS[i].wd_in;
      wd_float_i   = VECS[i].flt;
      sys_rst_i    = VECS[i].srst;
      supply_low_i = VECS[i].slow;
      for (int k = 0; k < int'(VECS[i].hold); k++) @(negedge clk_i);
      check(VECS[i].exp_n, int'(VECS[i].req), i);
    end
    // R6: same-cycle force; fault already low, so first clear then force
    wd_in_i = 1'b0;
    repeat (3) @(negedge clk_i);
    check(1'b1, 1, 100);
    supply_low_i = 1'b1;
    #1 check(1'b0, 6, 101);
    supply_low_i = 1'b0;
    #1 check(1'b1, 7, 102);
    // R8: async reset while timed out
    repeat (T + 2) @(negedge clk_i);
    check(1'b0, 2, 103);
    rst_ni = 1'b0;
    #1 check(1'b1, 8, 104);
    @(negedge clk_i);
    rst_ni = 1'b1;
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk_i);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired: done=%b expected 1", done);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule